// File: doc/BRIEF.md
# Stop-Clock Power State Sequencer

This block sequences the low-power states of a processor bus interface. A system asserts an active-low stop request. Once an instruction boundary has passed and the write buffers are empty, the block requests a special bus cycle that announces the grant. It then waits for the bus acknowledge before it gates the core clock off. While granted, the system may stop the input clock entirely, and it may strobe a snoop. A snoop wakes the core for exactly one clock. Releasing the request starts a fixed wake-up delay, after which execution resumes.

The same grant path is reachable from the halted state. The block remembers which state the grant came from. On release it returns to the halted state and issues a fresh halt bus cycle, not a resume of normal execution. A hard or soft reset pulls the sequencer back to normal execution from any state. Two sticky flags report misuse by the system: a request that is withdrawn before its grant cycle was acknowledged, and a request that is asserted again too soon after a grant.

Top module: `stpclk_power_ctrl`

## Requirements
- R1: After rst_n is held low, pwr_state reads 0, core_clk_en is 1, cyc_valid is 0 and both error flags are 0. The pwr_state codes are: 0 normal, 1 halted, 2 stop-granted, 3 clock-stopped, 4 snoop, 5 drain, 6 grant cycle, 7 halt cycle, 8 wake-up.
- R2: An accepted request (stop_req_n low) in normal (0) moves to drain (5). Drain is left for the grant cycle (6) only once an insn_boundary pulse has been seen during drain and wbuf_empty is high.
- R3: During a grant cycle cyc_valid is 1, cyc_addr is 0x0000_0010, cyc_be is 4'b1011, cyc_mio is 0, cyc_dc is 0 and cyc_wr is 1. A halt cycle carries the same encoding except that the address is 0x0000_0000. No other bus cycle is ever requested.
- R4: The grant cycle (6) is held until bus_rdy or bus_brdy is high. The next clock enters stop-granted (2).
- R5: While bus_granted is high, a stop request in normal is not accepted. It is taken one clock after bus_granted falls.
- R6: Releasing the request in stop-granted enters wake-up (8) for EXIT_DLY clocks (default 10). The state then becomes normal (0), or halt cycle (7) when the grant was entered from halted.
- R7: A halt_exec pulse in normal issues a halt cycle (7). Its acknowledge enters halted (1). A request accepted in halted goes through drain (5) with the boundary taken as already seen. On release a new halt cycle is issued.
- R8: clk_running low in stop-granted enters clock-stopped (3). clk_running high again returns to stop-granted on the next clock, with no bus cycle.
- R9: snoop_strobe in stop-granted or halted enters snoop (4) for exactly one clock. The state then returns to where it came from, with no bus cycle.
- R10: cpu_reset or cpu_sreset high forces normal (0) on the next clock, from any state, ahead of every other input.
- R11: After a grant acknowledge, asserting the request again after fewer than 5 deasserted clocks sets the sticky rearm_err.
- R12: Releasing the request in drain or grant cycle sets the sticky early_release_err. In drain, the release returns to the state the request came from, with no bus cycle.
- R13: core_clk_en is 1 in normal, drain, grant cycle and snoop, and 0 in halted, halt cycle, stop-granted, clock-stopped and wake-up.
- R14: In stop-granted, clock stop takes precedence over snoop, and snoop over release. A release that arrives together with a snoop takes effect on the clock after the snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| cpu_reset | input | 1 | Hard processor reset, forces normal |
| cpu_sreset | input | 1 | Soft processor reset, forces normal |
| stop_req_n | input | 1 | Active-low stop-clock request |
| bus_granted | input | 1 | Bus handed to another master |
| bus_rdy | input | 1 | Non-burst bus cycle acknowledge |
| bus_brdy | input | 1 | Burst bus cycle acknowledge |
| insn_boundary | input | 1 | Instruction boundary pulse |
| wbuf_empty | input | 1 | Write buffers empty |
| halt_exec | input | 1 | HALT instruction executed pulse |
| snoop_strobe | input | 1 | External snoop address strobe |
| clk_running | input | 1 | Input clock is running |
| cyc_valid | output | 1 | Special bus cycle requested |
| cyc_addr | output | ADDR_W | Special cycle address |
| cyc_be | output | 4 | Special cycle byte enables (active low) |
| cyc_mio | output | 1 | Memory/IO type bit |
| cyc_dc | output | 1 | Data/control type bit |
| cyc_wr | output | 1 | Write/read type bit |
| core_clk_en | output | 1 | Core clock enable |
| pwr_state | output | 4 | Current sequencer state code |
| early_release_err | output | 1 | Sticky: request withdrawn before grant acknowledge |
| rearm_err | output | 1 | Sticky: request re-asserted too soon after grant |

## Verification
A snoop strobe and a release of the stop request can arrive on the same clock while the block is stop-granted. The bench drives both on one cycle. It expects snoop (4) with the core clock enabled on the next clock, then stop-granted again, and only after that the wake-up state followed by normal exactly EXIT_DLY clocks later. The bus-cycle scoreboard confirms that this collision produces no extra special cycle. A second overlap is a soft reset arriving together with a release in stop-granted. The reset must win and land in normal with no wake-up delay.

// File: rtl/stpclk_pkg.sv
// Shared state and cycle-kind types for the stop-clock power sequencer.
// Assumes: state codes are visible on the top-level pwr_state port and are
// therefore fixed values, not left to the tool.
package stpclk_pkg;

    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        PS_NORMAL    = 4'd0,
        PS_HALT      = 4'd1,
        PS_GRANT     = 4'd2,
        PS_CLKSTOP   = 4'd3,
        PS_SNOOP     = 4'd4,
        PS_DRAIN     = 4'd5,
        PS_GRANT_CYC = 4'd6,
        PS_HALT_CYC  = 4'd7,
        PS_WAKE      = 4'd8
    } pstate_e;

    typedef enum logic [1:0] {
        CYC_NONE  = 2'd0,
        CYC_HALT  = 2'd1,
        CYC_GRANT = 2'd2
    } cyc_kind_e;

endpackage

// File: rtl/stpclk_seq_fsm.sv
// Power state sequencer: tracks normal, halted, draining, grant cycle,
// stop-granted, clock-stopped, snoop and wake-up, and names the special
// bus cycle wanted in the current state.
// Assumes: all inputs are already synchronous to clk; stop_act is the
// active-high form of the request; bus_ack merges both acknowledges.
module stpclk_seq_fsm
    import stpclk_pkg::*;
#(
    parameter int EXIT_DLY = 10
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cpu_reset,
    input  logic      cpu_sreset,
    input  logic      stop_act,
    input  logic      bus_granted,
    input  logic      bus_ack,
    input  logic      insn_boundary,
    input  logic      wbuf_empty,
    input  logic      halt_exec,
    input  logic      snoop_strobe,
    input  logic      clk_running,
    output pstate_e   state,
    output cyc_kind_e cyc_kind,
    output logic      grant_ack
);

    localparam int CNT_W = (EXIT_DLY > 1) ? $clog2(EXIT_DLY) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(EXIT_DLY - 1);

    pstate_e          st_q, st_d;
    pstate_e          ret_q, ret_d;
    logic             from_halt_q, from_halt_d;
    logic             bnd_q, bnd_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             any_reset;

    assign any_reset = cpu_reset | cpu_sreset;

    // Next-state and side-register computation for every state.
    always_comb begin
        st_d        = st_q;
        ret_d       = ret_q;
        from_halt_d = from_halt_q;
        bnd_d       = bnd_q;
        cnt_d       = cnt_q;
        if (any_reset) begin
            st_d        = PS_NORMAL;
            from_halt_d = 1'b0;
            bnd_d       = 1'b0;
        end else begin
            case (st_q)
                PS_NORMAL: begin
                    if (halt_exec) begin
                        st_d = PS_HALT_CYC;
                    end else if (stop_act && !bus_granted) begin
                        st_d        = PS_DRAIN;
                        from_halt_d = 1'b0;
                        bnd_d       = 1'b0;
                    end
                end
                PS_HALT: begin
                    if (snoop_strobe) begin
                        st_d  = PS_SNOOP;
                        ret_d = PS_HALT;
                    end else if (stop_act && !bus_granted) begin
                        st_d        = PS_DRAIN;
                        from_halt_d = 1'b1;
                        bnd_d       = 1'b1;
                    end
                end
                PS_DRAIN: begin
                    if (!stop_act) begin
                        st_d = from_halt_q ? PS_HALT : PS_NORMAL;
                    end else begin
                        if (insn_boundary) bnd_d = 1'b1;
                        if ((bnd_q || insn_boundary) && wbuf_empty)
                            st_d = PS_GRANT_CYC;
                    end
                end
                PS_GRANT_CYC: begin
                    if (bus_ack) st_d = PS_GRANT;
                end
                PS_GRANT: begin
                    if (!clk_running) begin
                        st_d = PS_CLKSTOP;
                    end else if (snoop_strobe) begin
                        st_d  = PS_SNOOP;
                        ret_d = PS_GRANT;
                    end else if (!stop_act) begin
                        st_d  = PS_WAKE;
                        cnt_d = CNT_LOAD;
                    end
                end
                PS_CLKSTOP: begin
                    if (clk_running) st_d = PS_GRANT;
                end
                PS_SNOOP: begin
                    st_d = ret_q;
                end
                PS_WAKE: begin
                    if (cnt_q == '0) st_d = from_halt_q ? PS_HALT_CYC : PS_NORMAL;
                    else             cnt_d = cnt_q - 1'b1;
                end
                PS_HALT_CYC: begin
                    if (bus_ack) st_d = PS_HALT;
                end
                default: st_d = PS_NORMAL;
            endcase
        end
    end

    // State and side registers, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= PS_NORMAL;
            ret_q       <= PS_GRANT;
            from_halt_q <= 1'b0;
            bnd_q       <= 1'b0;
            cnt_q       <= '0;
        end else begin
            st_q        <= st_d;
            ret_q       <= ret_d;
            from_halt_q <= from_halt_d;
            bnd_q       <= bnd_d;
            cnt_q       <= cnt_d;
        end
    end

    // Map the state to the special cycle it requests.
    always_comb begin
        case (st_q)
            PS_GRANT_CYC: cyc_kind = CYC_GRANT;
            PS_HALT_CYC:  cyc_kind = CYC_HALT;
            default:      cyc_kind = CYC_NONE;
        endcase
    end

    assign state     = st_q;
    assign grant_ack = (st_q == PS_GRANT_CYC) && bus_ack && !any_reset;

    // R4
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_GRANT_CYC && !bus_ack && !any_reset) |=> st_q == PS_GRANT_CYC);
    // R2
    drain_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_DRAIN && !wbuf_empty && !any_reset) |=> st_q != PS_GRANT_CYC);
    // R5
    granted_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_NORMAL && bus_granted && !halt_exec && !any_reset) |=> st_q == PS_NORMAL);
    // R8
    clk_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_CLKSTOP && clk_running && !any_reset) |=> st_q == PS_GRANT);
    // R9
    snoop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_SNOOP) |=> st_q != PS_SNOOP);
    // R10
    reset_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_reset |=> st_q == PS_NORMAL);

endmodule

// File: rtl/stpclk_cyc_enc.sv
// Special bus cycle encoder: turns the requested cycle kind into address,
// byte enables and the three cycle-type bits.
// Assumes: both special cycles are the same type and differ only in address.
module stpclk_cyc_enc
    import stpclk_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                BE_W       = 4,
    parameter logic [ADDR_W-1:0] GRANT_ADDR = 'h10,
    parameter logic [ADDR_W-1:0] HALT_ADDR  = 'h0,
    parameter logic [BE_W-1:0]   SPEC_BE    = 4'b1011
) (
    input  cyc_kind_e         kind,
    output logic              valid,
    output logic [ADDR_W-1:0] addr,
    output logic [BE_W-1:0]   be,
    output logic              mio,
    output logic              dc,
    output logic              wr
);

    // Drive the bus fields for the current cycle kind; idle is all inactive.
    always_comb begin
        valid = 1'b0;
        addr  = '0;
        be    = '1;
        mio   = 1'b0;
        dc    = 1'b0;
        wr    = 1'b0;
        case (kind)
            CYC_GRANT: begin
                valid = 1'b1;
                addr  = GRANT_ADDR;
                be    = SPEC_BE;
                wr    = 1'b1;
            end
            CYC_HALT: begin
                valid = 1'b1;
                addr  = HALT_ADDR;
                be    = SPEC_BE;
                wr    = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/stpclk_rule_mon.sv
// Protocol rule monitor: sticky flags for a request withdrawn before its
// grant acknowledge, and for a request re-asserted within the minimum gap.
// Assumes: grant_ack pulses for the single clock the grant cycle is acked.
module stpclk_rule_mon
    import stpclk_pkg::*;
#(
    parameter int REARM_GAP = 5
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    stop_act,
    input  pstate_e state,
    input  logic    grant_ack,
    output logic    early_err,
    output logic    rearm_err
);

    localparam int GAP_W = $clog2(REARM_GAP + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(REARM_GAP);

    logic             armed_q;
    logic [GAP_W-1:0] gap_q;
    logic             early_hit, rearm_hit;

    assign early_hit = !stop_act && (state == PS_DRAIN || state == PS_GRANT_CYC);
    assign rearm_hit = armed_q && stop_act && gap_q != '0 && gap_q < GAP_MAX;

    // Count deasserted clocks after a grant acknowledge until the gap is met.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            gap_q   <= '0;
        end else if (grant_ack) begin
            armed_q <= 1'b1;
            gap_q   <= '0;
        end else if (armed_q) begin
            if (stop_act) begin
                gap_q <= '0;
            end else if (gap_q == GAP_MAX - 1'b1) begin
                armed_q <= 1'b0;
                gap_q   <= '0;
            end else begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    // Sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            early_err <= 1'b0;
            rearm_err <= 1'b0;
        end else begin
            if (early_hit) early_err <= 1'b1;
            if (rearm_hit) rearm_err <= 1'b1;
        end
    end

    // R12
    early_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        early_err |=> early_err);
    // R11
    rearm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_err |=> rearm_err);

endmodule

// File: rtl/stpclk_power_ctrl.sv
// Top of the stop-clock power sequencer: joins the state machine, the
// special cycle encoder and the rule monitor, and drives the core clock
// enable from the state.
// Assumes: inputs are synchronous to clk; reset is synchronous active-low.
module stpclk_power_ctrl
    import stpclk_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                EXIT_DLY   = 10,
    parameter int                REARM_GAP  = 5,
    parameter logic [ADDR_W-1:0] GRANT_ADDR = 'h10,
    parameter logic [ADDR_W-1:0] HALT_ADDR  = 'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_reset,
    input  logic              cpu_sreset,
    input  logic              stop_req_n,
    input  logic              bus_granted,
    input  logic              bus_rdy,
    input  logic              bus_brdy,
    input  logic              insn_boundary,
    input  logic              wbuf_empty,
    input  logic              halt_exec,
    input  logic              snoop_strobe,
    input  logic              clk_running,
    output logic              cyc_valid,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [3:0]        cyc_be,
    output logic              cyc_mio,
    output logic              cyc_dc,
    output logic              cyc_wr,
    output logic              core_clk_en,
    output logic [3:0]        pwr_state,
    output logic              early_release_err,
    output logic              rearm_err
);

    pstate_e   st;
    cyc_kind_e kind;
    logic      grant_ack;
    logic      stop_act;

    assign stop_act = !stop_req_n;

    stpclk_seq_fsm #(.EXIT_DLY(EXIT_DLY)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_reset     (cpu_reset),
        .cpu_sreset    (cpu_sreset),
        .stop_act      (stop_act),
        .bus_granted   (bus_granted),
        .bus_ack       (bus_rdy | bus_brdy),
        .insn_boundary (insn_boundary),
        .wbuf_empty    (wbuf_empty),
        .halt_exec     (halt_exec),
        .snoop_strobe  (snoop_strobe),
        .clk_running   (clk_running),
        .state         (st),
        .cyc_kind      (kind),
        .grant_ack     (grant_ack)
    );

    stpclk_cyc_enc #(
        .ADDR_W     (ADDR_W),
        .BE_W       (4),
        .GRANT_ADDR (GRANT_ADDR),
        .HALT_ADDR  (HALT_ADDR),
        .SPEC_BE    (4'b1011)
    ) u_enc (
        .kind  (kind),
        .valid (cyc_valid),
        .addr  (cyc_addr),
        .be    (cyc_be),
        .mio   (cyc_mio),
        .dc    (cyc_dc),
        .wr    (cyc_wr)
    );

    stpclk_rule_mon #(.REARM_GAP(REARM_GAP)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_act  (stop_act),
        .state     (st),
        .grant_ack (grant_ack),
        .early_err (early_release_err),
        .rearm_err (rearm_err)
    );

    // Core clock runs while executing, draining, in the grant cycle or snooping.
    always_comb begin
        case (st)
            PS_NORMAL, PS_DRAIN, PS_GRANT_CYC, PS_SNOOP: core_clk_en = 1'b1;
            default:                                    core_clk_en = 1'b0;
        endcase
    end

    assign pwr_state = st;

    // R3
    grant_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_GRANT_CYC) |-> (cyc_valid && cyc_addr == GRANT_ADDR &&
            cyc_be == 4'b1011 && !cyc_mio && !cyc_dc && cyc_wr));
    // R13
    grant_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == PS_GRANT && core_clk_en) |-> (st == PS_SNOOP || st == PS_NORMAL));

endmodule

// File: tb/stpclk_power_ctrl_bench.sv
`timescale 1ns/1ps
module stpclk_power_ctrl_bench;

    localparam int EXIT_DLY = 10;

    logic        clk = 1'b0;
    logic        rst_n, cpu_reset, cpu_sreset, stop_req_n, bus_granted;
    logic        bus_rdy, bus_brdy, insn_boundary, wbuf_empty, halt_exec;
    logic        snoop_strobe, clk_running;
    logic        cyc_valid, cyc_mio, cyc_dc, cyc_wr, core_clk_en;
    logic [31:0] cyc_addr;
    logic [3:0]  cyc_be, pwr_state;
    logic        early_release_err, rearm_err;

    int n_chk  = 0;
    int n_fail = 0;
    int n_cyc  = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [31:0] addr;
        logic [3:0]  be;
    } exp_cyc_t;
    exp_cyc_t exp_q[$];
    logic prev_valid = 1'b0;

    always #4 clk = ~clk;

    stpclk_power_ctrl #(.EXIT_DLY(EXIT_DLY)) u_stpclk_power_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_reset(cpu_reset), .cpu_sreset(cpu_sreset),
        .stop_req_n(stop_req_n), .bus_granted(bus_granted), .bus_rdy(bus_rdy),
        .bus_brdy(bus_brdy), .insn_boundary(insn_boundary), .wbuf_empty(wbuf_empty),
        .halt_exec(halt_exec), .snoop_strobe(snoop_strobe), .clk_running(clk_running),
        .cyc_valid(cyc_valid), .cyc_addr(cyc_addr), .cyc_be(cyc_be), .cyc_mio(cyc_mio),
        .cyc_dc(cyc_dc), .cyc_wr(cyc_wr), .core_clk_en(core_clk_en),
        .pwr_state(pwr_state), .early_release_err(early_release_err),
        .rearm_err(rearm_err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_state(input logic [3:0] exp, input string tag);
        check(pwr_state == exp, tag, "state", 32'(pwr_state), 32'(exp));
    endtask

    task automatic wait_state(input logic [3:0] exp, input int maxc, input string tag);
        for (int i = 0; i < maxc && pwr_state != exp; i++) tick(1);
        chk_state(exp, tag);
    endtask

    // Driver side of the scoreboard: expected special cycles.
    task automatic push_grant();
        exp_q.push_back('{addr: 32'h10, be: 4'b1011});
    endtask
    task automatic push_halt();
        exp_q.push_back('{addr: 32'h0, be: 4'b1011});
    endtask

    task automatic ack(input bit burst);
        if (burst) bus_brdy = 1'b1; else bus_rdy = 1'b1;
        tick(1);
        bus_brdy = 1'b0;
        bus_rdy  = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: every new special cycle is compared with the queue head (R3).
    always @(negedge clk) begin
        if (rst_n === 1'b1 && cyc_valid && !prev_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3", "unexpected cycle addr", cyc_addr, 32'hFFFF_FFFF);
            end else begin
                exp_cyc_t e;
                e = exp_q.pop_front();
                check(cyc_addr == e.addr, "R3", "cycle addr", cyc_addr, e.addr);
                check(cyc_be == e.be, "R3", "cycle be", 32'(cyc_be), 32'(e.be));
                check({cyc_mio, cyc_dc, cyc_wr} == 3'b001, "R3", "cycle type",
                      32'({cyc_mio, cyc_dc, cyc_wr}), 32'h1);
            end
        end
        prev_valid = cyc_valid;
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 20000) begin
            check(1'b0, "WDOG", "timeout", n_cyc, 20000);
            finish_run();
        end
    end

    initial begin
        rst_n = 0; cpu_reset = 0; cpu_sreset = 0; stop_req_n = 1; bus_granted = 0;
        bus_rdy = 0; bus_brdy = 0; insn_boundary = 0; wbuf_empty = 0; halt_exec = 0;
        snoop_strobe = 0; clk_running = 1;
        tick(3);
        rst_n = 1;
        tick(1);
        // R1 reset state
        chk_state(4'd0, "R1");
        check(core_clk_en, "R1", "clk_en", 32'(core_clk_en), 1);
        check(!cyc_valid, "R1", "cyc_valid", 32'(cyc_valid), 0);
        check(!early_release_err && !rearm_err, "R1", "flags",
              32'({early_release_err, rearm_err}), 0);

        // R2 drain waits for boundary and empty buffers
        stop_req_n = 0;
        tick(1); chk_state(4'd5, "R2");
        check(core_clk_en, "R13", "clk_en drain", 32'(core_clk_en), 1);
        tick(2); chk_state(4'd5, "R2");
        insn_boundary = 1; tick(1); insn_boundary = 0;
        chk_state(4'd5, "R2");
        push_grant();
        wbuf_empty = 1;
        tick(1); chk_state(4'd6, "R2");
        // R4 held until acknowledge
        tick(3); chk_state(4'd6, "R4");
        ack(1'b1);
        chk_state(4'd2, "R4");
        check(!core_clk_en, "R13", "clk_en granted", 32'(core_clk_en), 0);

        // R8 clock stop and restart
        clk_running = 0;
        tick(1); chk_state(4'd3, "R8");
        check(!cyc_valid, "R8", "no cycle", 32'(cyc_valid), 0);
        tick(2);
        clk_running = 1;
        tick(1); chk_state(4'd2, "R8");

        // R14 snoop and release on the same clock
        snoop_strobe = 1; stop_req_n = 1;
        tick(1); snoop_strobe = 0;
        chk_state(4'd4, "R14");
        check(core_clk_en, "R9", "clk_en snoop", 32'(core_clk_en), 1);
        tick(1); chk_state(4'd2, "R14");
        tick(1); chk_state(4'd8, "R6");
        check(!core_clk_en, "R13", "clk_en wake", 32'(core_clk_en), 0);
        tick(EXIT_DLY - 1); chk_state(4'd8, "R6");
        tick(1); chk_state(4'd0, "R6");

        // R5 bus granted elsewhere blocks the request
        bus_granted = 1; stop_req_n = 0;
        tick(3); chk_state(4'd0, "R5");
        bus_granted = 0;
        tick(1); chk_state(4'd5, "R5");
        // R12 release during drain
        stop_req_n = 1;
        tick(1); chk_state(4'd0, "R12");
        check(early_release_err, "R12", "early flag", 32'(early_release_err), 1);
        check(!rearm_err, "R11", "no rearm flag", 32'(rearm_err), 0);

        // R7 halt path
        push_halt();
        halt_exec = 1; tick(1); halt_exec = 0;
        chk_state(4'd7, "R7");
        check(!core_clk_en, "R13", "clk_en halt cycle", 32'(core_clk_en), 0);
        ack(1'b0);
        chk_state(4'd1, "R7");
        snoop_strobe = 1; tick(1); snoop_strobe = 0;
        chk_state(4'd4, "R9");
        tick(1); chk_state(4'd1, "R9");
        push_grant();
        stop_req_n = 0;
        tick(1); chk_state(4'd5, "R7");
        tick(1); chk_state(4'd6, "R7");
        ack(1'b0);
        chk_state(4'd2, "R4");
        push_halt();
        stop_req_n = 1;
        tick(EXIT_DLY + 1); chk_state(4'd7, "R7");
        ack(1'b1);
        chk_state(4'd1, "R7");
        check(!rearm_err, "R11", "no rearm flag", 32'(rearm_err), 0);

        // R11 re-assert too soon after grant
        push_grant();
        stop_req_n = 0;
        tick(2); chk_state(4'd6, "R7");
        ack(1'b0);
        chk_state(4'd2, "R11");
        push_halt();
        stop_req_n = 1;
        tick(2);
        stop_req_n = 0;
        tick(1);
        check(rearm_err, "R11", "rearm flag", 32'(rearm_err), 1);
        chk_state(4'd8, "R11");
        wait_state(4'd7, 20, "R7");
        push_grant();
        ack(1'b0);
        chk_state(4'd1, "R7");
        wait_state(4'd6, 5, "R7");
        ack(1'b1);
        chk_state(4'd2, "R4");

        // R10 soft reset wins over release
        cpu_sreset = 1; stop_req_n = 1;
        tick(1); cpu_sreset = 0;
        chk_state(4'd0, "R10");
        check(core_clk_en, "R13", "clk_en normal", 32'(core_clk_en), 1);
        // R10 hard reset from halted
        push_halt();
        halt_exec = 1; tick(1); halt_exec = 0;
        ack(1'b0);
        chk_state(4'd1, "R7");
        cpu_reset = 1; tick(1); cpu_reset = 0;
        chk_state(4'd0, "R10");

        tick(2);
        check(exp_q.size() == 0, "R3", "missing cycles", exp_q.size(), 0);
        check(early_release_err, "R12", "early flag sticky", 32'(early_release_err), 1);
        finish_run();
    end

endmodule